// File: doc/BRIEF.md
# Serial-port frame-sync generator

This block produces the frame-synchronization pulse train of a multi-channel serial port and routes frame syncs to the receive and transmit sides. It runs on the divided bit clock that the sample-rate generator produces, and everything it does is counted in cycles of that clock. The block only runs while both the rate generator and the frame-sync logic are enabled. Otherwise its generated pulse is held low and its counters are cleared.

In free-running mode a reloading period counter starts a new pulse every (period+1) cycles, and a width counter keeps the pulse high for (width+1) cycles. If the width is not shorter than the period, the pulse stays high without gaps. In synchronized mode there is no periodic restart. Instead, each rising transition seen on the external receive frame-sync pin, after a two-flop synchronizer, starts a pulse and restarts both counters, even when a pulse is already running. A separate routing stage picks the receive frame sync from either the generated pulse or the external receive pin. It picks the transmit frame sync from the external transmit pin, from the generated pulse, or from the generated pulse masked while the transmit buffer is empty.

Top module: `fsgen_top`

## Requirements
- R1: With width field W smaller than period field P in free-running mode, each generated pulse (`fsg`) stays high for exactly W+1 consecutive cycles.
- R2: In free-running mode, consecutive pulse starts are exactly P+1 cycles apart.
- R3: When W is greater than or equal to P, `fsg` stays high in every cycle once running, including W=0 with P=0.
- R4: The block is running only when `srg_en` and `fs_en` are both 1. In the cycle after an edge that sees it not running, `fsg` is 0. On the first edge that sees it running (free mode), a period starts, so `fsg` is 1 in the following cycle. While `rst_n` is 0 at an edge, all outputs that come from the generator are 0.
- R5: In synchronized mode (`sync_mode`=1), a low-to-high change on `rx_fs_pin` first sampled at edge n makes `fsg` rise after edge n+2. The pulse then lasts W+1 cycles.
- R6: In synchronized mode, a new pin edge detected while a pulse is still high restarts the width count, so the pulse lasts W+1 cycles from the restart.
- R7: In synchronized mode, no pulse is produced without a pin edge, whatever P is.
- R8: New P or W values applied in the middle of a period are used only from the next pulse start.
- R9: `rx_fs` equals `fsg` when `rx_src_int`=1, and equals `rx_fs_pin` when `rx_src_int`=0.
- R10: `tx_fs` equals `tx_fs_pin` when `tx_src_int`=0. It equals `fsg` when `tx_src_int`=1 and `tx_src_gen`=1. It equals `fsg` AND NOT `tx_buf_empty` when `tx_src_int`=1 and `tx_src_gen`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate generator output clock |
| rst_n | input | 1 | Synchronous active-low reset |
| srg_en | input | 1 | Rate generator enabled |
| fs_en | input | 1 | Frame-sync logic enabled |
| period_cfg | input | 12 | Period field P, pulse starts every P+1 cycles |
| width_cfg | input | 8 | Width field W, pulse lasts W+1 cycles |
| sync_mode | input | 1 | 1: pulses start on external pin edges |
| rx_src_int | input | 1 | 1: receive sync taken from the generator |
| tx_src_int | input | 1 | 1: transmit sync produced internally |
| tx_src_gen | input | 1 | 1: internal transmit sync is the raw generator pulse; 0: buffer-gated |
| rx_fs_pin | input | 1 | External receive frame-sync pin, also the synchronizing source |
| tx_fs_pin | input | 1 | External transmit frame-sync pin |
| tx_buf_empty | input | 1 | Transmit buffer holds no data |
| fsg | output | 1 | Generated frame-sync pulse |
| rx_fs | output | 1 | Selected receive frame sync |
| tx_fs | output | 1 | Selected transmit frame sync |

## Verification
Two things can fall in the same cycle. A pulse start, whether a period reload or a detected pin edge, can coincide with the last cycle of the running pulse. A configuration change can land on the edge that reloads the period. The bench places pin edges both inside a long pulse and on the cycle its width runs out, and it rewrites P and W in the middle of a period. It also sets W at or above P, so that a restart falls while the width counter is still nonzero. On every clock, a behavioural phase-count model compares `fsg`, `rx_fs` and `tx_fs`, and the model decides which event wins purely from the requirements.

// File: rtl/fsgen_pkg.sv
// Package: shared sizes and types for the frame-sync generator.
// Assumes one clock domain (the rate generator output clock).
package fsgen_pkg;

    localparam int PER_W = 12;   // width of period field
    localparam int WID_W = 8;    // width of pulse-width field

    // Transmit frame-sync source choice after decoding the mode bits.
    typedef enum logic [1:0] {
        TXS_PIN   = 2'd0,
        TXS_GEN   = 2'd1,
        TXS_GATED = 2'd2
    } tx_src_e;

    // Routing selection bundle.
    typedef struct packed {
        logic rx_int;
        logic tx_int;
        logic tx_gen;
    } route_cfg_t;

    // Decode routing bits into a transmit source.
    function automatic tx_src_e decode_tx(input route_cfg_t c);
        if (!c.tx_int)     return TXS_PIN;
        else if (c.tx_gen) return TXS_GEN;
        else               return TXS_GATED;
    endfunction

endpackage

// File: rtl/fsgen_sync.sv
// Module: fsgen_sync
// Brings the external frame-sync pin into the clock domain through a
// STAGES-deep flop chain and flags a one-cycle rising-edge event.
// Assumes the pin is asynchronous; the chain runs whenever out of reset.
module fsgen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);

    logic [STAGES-1:0] chain;
    logic              last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= pin;
                end
            end else begin : g_next
                // Shift toward the synchronized end.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last_q;

    // R5: a detected rise lasts a single cycle.
    a_r5_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/fsgen_core.sv
// Module: fsgen_core
// Period and width counters producing the generated frame-sync pulse.
// Free mode restarts when the period counter reaches zero; sync mode
// restarts on each edge event. Configuration is loaded only at a start.
// Assumes run already combines both enables.
module fsgen_core #(
    parameter int PER_W = 12,
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sync_mode,
    input  logic             ext_rise,
    input  logic [PER_W-1:0] period_cfg,
    input  logic [WID_W-1:0] width_cfg,
    output logic             fsg
);

    logic [PER_W-1:0] per_cnt;
    logic [WID_W-1:0] wid_left;
    logic             started;
    logic             fsg_q;
    logic             per_done;
    logic             start;

    assign per_done = (per_cnt == '0);

    // Decide whether this cycle begins a new pulse.
    always_comb begin
        if (!run)          start = 1'b0;
        else if (sync_mode) start = ext_rise;
        else               start = !started || per_done;
    end

    // Counter and pulse state update.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            per_cnt  <= '0;
            wid_left <= '0;
            started  <= 1'b0;
            fsg_q    <= 1'b0;
        end else if (start) begin
            per_cnt  <= period_cfg;
            wid_left <= width_cfg;
            started  <= 1'b1;
            fsg_q    <= 1'b1;
        end else begin
            if (!per_done) per_cnt <= per_cnt - 1'b1;
            if (wid_left != '0) begin
                wid_left <= wid_left - 1'b1;
                fsg_q    <= 1'b1;
            end else begin
                fsg_q    <= 1'b0;
            end
        end
    end

    assign fsg = fsg_q;

    // R4: once not running, the pulse is low on the next cycle.
    a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !fsg);

    // R2: the period counter steps down by one while a period is in progress.
    a_r2_period_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sync_mode && !per_done) |=> (per_cnt == $past(per_cnt) - 1'b1));

    // R1: remaining width keeps the pulse high.
    a_r1_width_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wid_left != '0) |=> fsg);

    // R7: in sync mode, no edge and no remaining width means no pulse.
    a_r7_no_edge_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sync_mode && !ext_rise && wid_left == '0) |=> !fsg);

endmodule

// File: rtl/fsgen_route.sv
// Module: fsgen_route
// Selects the receive and transmit frame syncs from the generated pulse,
// the external pins, or the generated pulse masked by buffer emptiness.
// Purely combinational; clock is used only by its checks.
module fsgen_route
    import fsgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  route_cfg_t cfg,
    input  logic       gen_fs,
    input  logic       rx_pin,
    input  logic       tx_pin,
    input  logic       buf_empty,
    output logic       rx_fs,
    output logic       tx_fs
);

    tx_src_e tx_sel;

    assign tx_sel = decode_tx(cfg);

    // Receive side: generator or external pin.
    always_comb begin
        rx_fs = cfg.rx_int ? gen_fs : rx_pin;
    end

    // Transmit side: pin, raw generator, or generator gated by data.
    always_comb begin
        case (tx_sel)
            TXS_PIN:   tx_fs = tx_pin;
            TXS_GEN:   tx_fs = gen_fs;
            TXS_GATED: tx_fs = gen_fs & ~buf_empty;
            default:   tx_fs = 1'b0;
        endcase
    end

    // R10: an empty buffer blocks the gated transmit sync.
    a_r10_gated_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.tx_int && !cfg.tx_gen && buf_empty) |-> !tx_fs);

    // R9: external receive source follows the pin.
    a_r9_rx_pin: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.rx_int |-> (rx_fs == rx_pin));

endmodule

// File: rtl/fsgen_top.sv
// Module: fsgen_top
// Frame-sync generator: pin synchronizer, period/width core and source
// routing. Runs only when both the rate generator and frame-sync enables
// are set. Assumes all inputs other than the pins are static per cycle.
module fsgen_top
    import fsgen_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srg_en,
    input  logic             fs_en,
    input  logic [PER_W-1:0] period_cfg,
    input  logic [WID_W-1:0] width_cfg,
    input  logic             sync_mode,
    input  logic             rx_src_int,
    input  logic             tx_src_int,
    input  logic             tx_src_gen,
    input  logic             rx_fs_pin,
    input  logic             tx_fs_pin,
    input  logic             tx_buf_empty,
    output logic             fsg,
    output logic             rx_fs,
    output logic             tx_fs
);

    logic       run;
    logic       ext_rise;
    route_cfg_t rcfg;

    assign run  = srg_en & fs_en;
    assign rcfg = '{rx_int: rx_src_int, tx_int: tx_src_int, tx_gen: tx_src_gen};

    fsgen_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (rx_fs_pin),
        .rise (ext_rise)
    );

    fsgen_core #(.PER_W(PER_W), .WID_W(WID_W)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .sync_mode (sync_mode),
        .ext_rise  (ext_rise),
        .period_cfg(period_cfg),
        .width_cfg (width_cfg),
        .fsg       (fsg)
    );

    fsgen_route i_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (rcfg),
        .gen_fs   (fsg),
        .rx_pin   (rx_fs_pin),
        .tx_pin   (tx_fs_pin),
        .buf_empty(tx_buf_empty),
        .rx_fs    (rx_fs),
        .tx_fs    (tx_fs)
    );

    // R4: disabled enables keep the generated pulse low next cycle.
    a_r4_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!srg_en || !fs_en) |=> !fsg);

endmodule

// File: tb/test_fsgen_top.sv
// Bench: behavioural phase-count model compared with the outputs every clock.
module test_fsgen_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        srg_en = 1'b0, fs_en = 1'b0;
    logic [11:0] period_cfg = '0;
    logic [7:0]  width_cfg = '0;
    logic        sync_mode = 1'b0;
    logic        rx_src_int = 1'b1, tx_src_int = 1'b1, tx_src_gen = 1'b1;
    logic        rx_fs_pin = 1'b0, tx_fs_pin = 1'b0, tx_buf_empty = 1'b0;
    logic        fsg, rx_fs, tx_fs;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R4";
    bit    done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    fsgen_top i_fsgen_top (
        .clk(clk), .rst_n(rst_n), .srg_en(srg_en), .fs_en(fs_en),
        .period_cfg(period_cfg), .width_cfg(width_cfg), .sync_mode(sync_mode),
        .rx_src_int(rx_src_int), .tx_src_int(tx_src_int), .tx_src_gen(tx_src_gen),
        .rx_fs_pin(rx_fs_pin), .tx_fs_pin(tx_fs_pin), .tx_buf_empty(tx_buf_empty),
        .fsg(fsg), .rx_fs(rx_fs), .tx_fs(tx_fs)
    );

    // Reference model state: phase since last pulse start.
    int pin_hist[$];
    bit m_started = 0, m_fsg = 0, m_prev_sync = 0;
    int phase = 0, p_lat = 0, w_lat = 0;

    task automatic check(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Update model at each edge, then compare mid-cycle.
    always @(posedge clk) begin
        bit edge_seen, start, sync_lvl;
        if (!rst_n) begin
            pin_hist = '{0, 0};
            m_prev_sync = 0; m_started = 0; m_fsg = 0; phase = 0;
        end else begin
            sync_lvl  = pin_hist[0] != 0;       // pin seen two samples ago
            edge_seen = sync_lvl && !m_prev_sync;
            m_prev_sync = sync_lvl;
            pin_hist.push_back(int'(rx_fs_pin));
            void'(pin_hist.pop_front());
            if (!(srg_en && fs_en)) begin
                m_started = 0; m_fsg = 0; phase = 0;
            end else begin
                start = sync_mode ? edge_seen : (!m_started || phase == p_lat);
                if (start) begin
                    phase = 0; p_lat = period_cfg; w_lat = width_cfg; m_started = 1;
                end else if (phase < 1000000) phase++;
                m_fsg = m_started && (phase <= w_lat);
            end
        end
        #5;
        check("fsg", fsg, m_fsg);
        check("rx_fs", rx_fs, rx_src_int ? m_fsg : rx_fs_pin);
        check("tx_fs", tx_fs, !tx_src_int ? tx_fs_pin :
                               (tx_src_gen ? m_fsg : (m_fsg & ~tx_buf_empty)));
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin_pulse(input int hi, input int lo);
        rx_fs_pin = 1'b1; cyc(hi);
        rx_fs_pin = 1'b0; cyc(lo);
    endtask

    initial begin
        pin_hist = '{0, 0};
        cur_req = "R4"; cyc(3);
        rst_n = 1'b1; cyc(2);
        // R4: only one enable set keeps the pulse low.
        srg_en = 1'b1; cyc(4);
        // R1 R2: narrow pulse, longer period.
        cur_req = "R1/R2"; width_cfg = 8'd2; period_cfg = 12'd9; fs_en = 1'b1; cyc(40);
        // R8: change mid-period.
        cur_req = "R8"; cyc(3); width_cfg = 8'd4; period_cfg = 12'd6; cyc(30);
        // R3: width at or beyond period.
        cur_req = "R3"; width_cfg = 8'd7; period_cfg = 12'd3; cyc(20);
        width_cfg = 8'd0; period_cfg = 12'd0; cyc(10);
        // R4: drop and restore each enable.
        cur_req = "R4"; width_cfg = 8'd1; period_cfg = 12'd5; fs_en = 1'b0; cyc(5);
        fs_en = 1'b1; cyc(9); srg_en = 1'b0; cyc(4); srg_en = 1'b1; cyc(12);
        // R9: external receive source while the pin toggles.
        cur_req = "R9"; rx_src_int = 1'b0;
        for (int i = 0; i < 6; i++) pin_pulse(2, 3);
        rx_src_int = 1'b1;
        // R10: gated transmit source.
        cur_req = "R10"; tx_src_gen = 1'b0;
        for (int i = 0; i < 8; i++) begin tx_buf_empty = ~tx_buf_empty; cyc(3); end
        tx_buf_empty = 1'b1; cyc(10); tx_buf_empty = 1'b0; cyc(10);
        tx_src_int = 1'b0;
        for (int i = 0; i < 5; i++) begin tx_fs_pin = ~tx_fs_pin; cyc(2); end
        tx_src_int = 1'b1; tx_src_gen = 1'b1; tx_fs_pin = 1'b0;
        // R5: synchronized mode, pulses on pin edges.
        cur_req = "R5"; fs_en = 1'b0; cyc(2); sync_mode = 1'b1; width_cfg = 8'd3;
        period_cfg = 12'd4; fs_en = 1'b1; cyc(4);
        pin_pulse(2, 10); pin_pulse(1, 12);
        // R7: no edges, no pulses.
        cur_req = "R7"; cyc(30); rx_fs_pin = 1'b1; cyc(15);
        rx_fs_pin = 1'b0; cyc(5);
        // R6: edges inside a running pulse and on its last cycle.
        cur_req = "R6"; width_cfg = 8'd10;
        pin_pulse(1, 3); pin_pulse(1, 4); pin_pulse(1, 20);
        width_cfg = 8'd3; pin_pulse(1, 3); pin_pulse(1, 15);
        // R4: reset in the middle of synchronized activity.
        cur_req = "R4"; rx_fs_pin = 1'b1; rst_n = 1'b0; cyc(3); rst_n = 1'b1;
        rx_fs_pin = 1'b0; cyc(10);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule